// File: doc/BRIEF.md
# Dual Configuration Register Bank with Active-Set Select

This block keeps two full copies of a device's configuration registers, a foreground set and a background set, plus one selection bit that names the active set. Every host write lands in the active copy only, and every output and read returns the active copy's values. The inactive copy is left untouched.

Two single-cycle command pulses change the selection. One makes the foreground set active and the other makes the background set active. With this, a housekeeping task can reconfigure the device through the background set, and the device can then return to its foreground setup in one cycle without reloading anything.

Each copy holds these registers:
- a control word
- a segment-control word
- an address register
- a wide primary mask, written in segments
- a 2-bit persistent source pointer
- a 2-bit persistent destination pointer

A secondary mask is stored once and is shared by both sets.

Top module: `fgbg_regbank`

## Requirements
- R1: While rst_ni is low and after it is released, the foreground set is active (bank_bg_o = 0). In both copies the control word equals parameter CTL_RST, and every other register, including the shared mask, is zero.
- R2: A write strobe (wr_en_i = 1 at a rising clock edge) updates only the copy that is active at that edge. The other copy keeps all of its contents.
- R3: A set-background pulse (set_bg_i = 1, set_fg_i = 0) at an edge makes the background copy active from that edge on. All register outputs then show background values.
- R4: A set-foreground pulse (set_fg_i = 1, set_bg_i = 0) makes the foreground copy active again, with the contents it held before the switch.
- R5: Changing the active set modifies no register in either copy. It also leaves the shared mask unchanged.
- R6: When a write and a set-select pulse arrive at the same edge, the write goes to the copy that was active before the switch.
- R7: When both set-select pulses arrive at the same edge, the active set is unchanged.
- R8: Register codes for writes and reads are: 0 control, 1 segment control, 2 address, 3 primary mask, 4 source pointer, 5 destination pointer, 6 shared mask, 7 none. A mask write with segment index k replaces bits [16k+15:16k] and leaves the other segments unchanged.
- R9: The shared mask (code 6) is a single register. A value written while either set is active is visible on mr2_o under both sets.
- R10: rd_data_o combinationally returns the active copy's value of register rd_reg_i. For codes 3 and 6 it returns segment rd_seg_i, and narrower registers are zero-extended. Code 7 reads as zero, and a write with code 7 changes nothing.
- R11: The address register keeps wr_data_i[ADDR_W-1:0]. The pointer registers keep wr_data_i[PTR_W-1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_fg_i | input | 1 | Make foreground set active |
| set_bg_i | input | 1 | Make background set active |
| wr_en_i | input | 1 | Write strobe |
| wr_reg_i | input | 3 | Register code for the write |
| wr_seg_i | input | SEG_IDX_W | Segment index for mask writes |
| wr_data_i | input | SEG_W | Write data |
| rd_reg_i | input | 3 | Register code for the read port |
| rd_seg_i | input | SEG_IDX_W | Segment index for mask reads |
| rd_data_o | output | SEG_W | Read data from the active set |
| bank_bg_o | output | 1 | 1 when the background set is active |
| ctl_o | output | SEG_W | Active control word |
| segctl_o | output | SEG_W | Active segment-control word |
| addr_o | output | ADDR_W | Active address register |
| mr1_o | output | SEG_W*NUM_SEG | Active primary mask |
| psrc_o | output | PTR_W | Active source pointer |
| pdst_o | output | PTR_W | Active destination pointer |
| mr2_o | output | SEG_W*NUM_SEG | Shared secondary mask |

## Verification
The bench uses the default parameters: SEG_W = 16, NUM_SEG = 4, ADDR_W = 10, PTR_W = 2, and a nonzero CTL_RST.
- The four mask segments let every segment be written in isolation and read back.
- ADDR_W and PTR_W are narrower than the data bus, so truncation of the upper data bits can be seen at the outputs.
- The nonzero control reset value separates a copy that was never touched from one that was written with zero.

// File: rtl/fgbg_pkg.sv
package fgbg_pkg;
  typedef enum logic [2:0] {
    REG_CTL    = 3'd0,
    REG_SEGCTL = 3'd1,
    REG_ADDR   = 3'd2,
    REG_MR1    = 3'd3,
    REG_PSRC   = 3'd4,
    REG_PDST   = 3'd5,
    REG_MR2    = 3'd6,
    REG_NONE   = 3'd7
  } reg_id_e;

  localparam int unsigned NUM_COPIES = 2;
endpackage

// File: rtl/fgbg_sel.sv
module fgbg_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_fg_i,
  input  logic set_bg_i,
  output logic bg_o
);
  logic bg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bg_q <= 1'b0;
    end else if (set_bg_i && !set_fg_i) begin
      bg_q <= 1'b1;
    end else if (set_fg_i && !set_bg_i) begin
      bg_q <= 1'b0;
    end
  end

  assign bg_o = bg_q;

  // R3
  bg_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_bg_i && !set_fg_i) |=> bg_o);

  // R4
  fg_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_fg_i && !set_bg_i) |=> !bg_o);

  // R7
  both_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_fg_i == set_bg_i) |=> $stable(bg_o));
endmodule

// File: rtl/fgbg_copy.sv
module fgbg_copy
  import fgbg_pkg::*;
#(
  parameter int unsigned SEG_W     = 16,
  parameter int unsigned NUM_SEG   = 4,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned PTR_W     = 2,
  parameter logic [SEG_W-1:0] CTL_RST = '0,
  localparam int unsigned SEG_IDX_W = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
  localparam int unsigned MASK_W    = SEG_W * NUM_SEG
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  reg_id_e              wr_reg_i,
  input  logic [SEG_IDX_W-1:0] wr_seg_i,
  input  logic [SEG_W-1:0]     wr_data_i,
  output logic [SEG_W-1:0]     ctl_o,
  output logic [SEG_W-1:0]     segctl_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [MASK_W-1:0]    mr1_o,
  output logic [PTR_W-1:0]     psrc_o,
  output logic [PTR_W-1:0]     pdst_o
);
  logic hit_ctl, hit_segctl, hit_addr, hit_mr1, hit_psrc, hit_pdst;

  assign hit_ctl    = wr_en_i && (wr_reg_i == REG_CTL);
  assign hit_segctl = wr_en_i && (wr_reg_i == REG_SEGCTL);
  assign hit_addr   = wr_en_i && (wr_reg_i == REG_ADDR);
  assign hit_mr1    = wr_en_i && (wr_reg_i == REG_MR1);
  assign hit_psrc   = wr_en_i && (wr_reg_i == REG_PSRC);
  assign hit_pdst   = wr_en_i && (wr_reg_i == REG_PDST);

  logic [SEG_W-1:0]  ctl_q, segctl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PTR_W-1:0]  psrc_q, pdst_q;
  logic [SEG_W-1:0]  mr1_q [NUM_SEG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= CTL_RST;
    else if (hit_ctl) ctl_q <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) segctl_q <= '0;
    else if (hit_segctl) segctl_q <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else if (hit_addr) addr_q <= wr_data_i[ADDR_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) psrc_q <= '0;
    else if (hit_psrc) psrc_q <= wr_data_i[PTR_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pdst_q <= '0;
    else if (hit_pdst) pdst_q <= wr_data_i[PTR_W-1:0];
  end

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_mr1
    logic seg_hit;
    assign seg_hit = hit_mr1 && (wr_seg_i == SEG_IDX_W'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mr1_q[k] <= '0;
      else if (seg_hit) mr1_q[k] <= wr_data_i;
    end

    assign mr1_o[k*SEG_W +: SEG_W] = mr1_q[k];

    // R8
    mr1_seg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && wr_reg_i == REG_MR1 && wr_seg_i == SEG_IDX_W'(k))
        |=> $stable(mr1_o[k*SEG_W +: SEG_W]));
  end

  assign ctl_o    = ctl_q;
  assign segctl_o = segctl_q;
  assign addr_o   = addr_q;
  assign psrc_o   = psrc_q;
  assign pdst_o   = pdst_q;

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(ctl_o) && $stable(segctl_o) && $stable(addr_o)
                  && $stable(mr1_o) && $stable(psrc_o) && $stable(pdst_o)));

  // R11
  addr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_reg_i == REG_ADDR) |=> (addr_o == $past(wr_data_i[ADDR_W-1:0])));
endmodule

// File: rtl/fgbg_shared.sv
module fgbg_shared
  import fgbg_pkg::*;
#(
  parameter int unsigned SEG_W   = 16,
  parameter int unsigned NUM_SEG = 4,
  localparam int unsigned SEG_IDX_W = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
  localparam int unsigned MASK_W    = SEG_W * NUM_SEG
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  reg_id_e              wr_reg_i,
  input  logic [SEG_IDX_W-1:0] wr_seg_i,
  input  logic [SEG_W-1:0]     wr_data_i,
  output logic [MASK_W-1:0]    mr2_o
);
  logic hit_mr2;
  assign hit_mr2 = wr_en_i && (wr_reg_i == REG_MR2);

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_mr2
    logic [SEG_W-1:0] seg_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) seg_q <= '0;
      else if (hit_mr2 && (wr_seg_i == SEG_IDX_W'(k))) seg_q <= wr_data_i;
    end

    assign mr2_o[k*SEG_W +: SEG_W] = seg_q;
  end

  // R9
  mr2_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_reg_i == REG_MR2) |=> $stable(mr2_o));
endmodule

// File: rtl/fgbg_rdmux.sv
module fgbg_rdmux
  import fgbg_pkg::*;
#(
  parameter int unsigned SEG_W   = 16,
  parameter int unsigned NUM_SEG = 4,
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned PTR_W   = 2,
  localparam int unsigned SEG_IDX_W = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
  localparam int unsigned MASK_W    = SEG_W * NUM_SEG
) (
  input  reg_id_e              rd_reg_i,
  input  logic [SEG_IDX_W-1:0] rd_seg_i,
  input  logic [SEG_W-1:0]     ctl_i,
  input  logic [SEG_W-1:0]     segctl_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [MASK_W-1:0]    mr1_i,
  input  logic [PTR_W-1:0]     psrc_i,
  input  logic [PTR_W-1:0]     pdst_i,
  input  logic [MASK_W-1:0]    mr2_i,
  output logic [SEG_W-1:0]     rd_data_o
);
  logic [SEG_W-1:0] mr1_w [NUM_SEG];
  logic [SEG_W-1:0] mr2_w [NUM_SEG];

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_split
    assign mr1_w[k] = mr1_i[k*SEG_W +: SEG_W];
    assign mr2_w[k] = mr2_i[k*SEG_W +: SEG_W];
  end

  logic seg_ok;
  assign seg_ok = (32'(rd_seg_i) < NUM_SEG);

  always_comb begin
    rd_data_o = '0;
    case (rd_reg_i)
      REG_CTL:    rd_data_o = ctl_i;
      REG_SEGCTL: rd_data_o = segctl_i;
      REG_ADDR:   rd_data_o[ADDR_W-1:0] = addr_i;
      REG_MR1:    if (seg_ok) rd_data_o = mr1_w[rd_seg_i];
      REG_PSRC:   rd_data_o[PTR_W-1:0] = psrc_i;
      REG_PDST:   rd_data_o[PTR_W-1:0] = pdst_i;
      REG_MR2:    if (seg_ok) rd_data_o = mr2_w[rd_seg_i];
      default:    rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/fgbg_regbank.sv
module fgbg_regbank
  import fgbg_pkg::*;
#(
  parameter int unsigned SEG_W   = 16,
  parameter int unsigned NUM_SEG = 4,
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned PTR_W   = 2,
  parameter logic [SEG_W-1:0] CTL_RST = 16'h0c41,
  localparam int unsigned SEG_IDX_W = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
  localparam int unsigned MASK_W    = SEG_W * NUM_SEG
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_fg_i,
  input  logic                 set_bg_i,
  input  logic                 wr_en_i,
  input  logic [2:0]           wr_reg_i,
  input  logic [SEG_IDX_W-1:0] wr_seg_i,
  input  logic [SEG_W-1:0]     wr_data_i,
  input  logic [2:0]           rd_reg_i,
  input  logic [SEG_IDX_W-1:0] rd_seg_i,
  output logic [SEG_W-1:0]     rd_data_o,
  output logic                 bank_bg_o,
  output logic [SEG_W-1:0]     ctl_o,
  output logic [SEG_W-1:0]     segctl_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [MASK_W-1:0]    mr1_o,
  output logic [PTR_W-1:0]     psrc_o,
  output logic [PTR_W-1:0]     pdst_o,
  output logic [MASK_W-1:0]    mr2_o
);
  reg_id_e wr_id, rd_id;
  assign wr_id = reg_id_e'(wr_reg_i);
  assign rd_id = reg_id_e'(rd_reg_i);

  logic bg_q;

  fgbg_sel u_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_fg_i (set_fg_i),
    .set_bg_i (set_bg_i),
    .bg_o     (bg_q)
  );

  logic [SEG_W-1:0]  ctl_q    [NUM_COPIES];
  logic [SEG_W-1:0]  segctl_q [NUM_COPIES];
  logic [ADDR_W-1:0] addr_q   [NUM_COPIES];
  logic [MASK_W-1:0] mr1_q    [NUM_COPIES];
  logic [PTR_W-1:0]  psrc_q   [NUM_COPIES];
  logic [PTR_W-1:0]  pdst_q   [NUM_COPIES];

  // copy 0 = foreground, copy 1 = background; steering uses pre-edge selection
  for (genvar b = 0; b < NUM_COPIES; b++) begin : g_copy
    logic copy_we;
    assign copy_we = wr_en_i && (bg_q == 1'(b));

    fgbg_copy #(
      .SEG_W   (SEG_W),
      .NUM_SEG (NUM_SEG),
      .ADDR_W  (ADDR_W),
      .PTR_W   (PTR_W),
      .CTL_RST (CTL_RST)
    ) u_copy (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (copy_we),
      .wr_reg_i  (wr_id),
      .wr_seg_i  (wr_seg_i),
      .wr_data_i (wr_data_i),
      .ctl_o     (ctl_q[b]),
      .segctl_o  (segctl_q[b]),
      .addr_o    (addr_q[b]),
      .mr1_o     (mr1_q[b]),
      .psrc_o    (psrc_q[b]),
      .pdst_o    (pdst_q[b])
    );
  end

  fgbg_shared #(
    .SEG_W   (SEG_W),
    .NUM_SEG (NUM_SEG)
  ) u_shared (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_reg_i  (wr_id),
    .wr_seg_i  (wr_seg_i),
    .wr_data_i (wr_data_i),
    .mr2_o     (mr2_o)
  );

  assign bank_bg_o = bg_q;
  assign ctl_o     = ctl_q[bg_q];
  assign segctl_o  = segctl_q[bg_q];
  assign addr_o    = addr_q[bg_q];
  assign mr1_o     = mr1_q[bg_q];
  assign psrc_o    = psrc_q[bg_q];
  assign pdst_o    = pdst_q[bg_q];

  fgbg_rdmux #(
    .SEG_W   (SEG_W),
    .NUM_SEG (NUM_SEG),
    .ADDR_W  (ADDR_W),
    .PTR_W   (PTR_W)
  ) u_rdmux (
    .rd_reg_i  (rd_id),
    .rd_seg_i  (rd_seg_i),
    .ctl_i     (ctl_o),
    .segctl_i  (segctl_o),
    .addr_i    (addr_o),
    .mr1_i     (mr1_o),
    .psrc_i    (psrc_o),
    .pdst_i    (pdst_o),
    .mr2_i     (mr2_o),
    .rd_data_o (rd_data_o)
  );

  // R2
  fg_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bg_q |=> ($stable(ctl_q[0]) && $stable(segctl_q[0]) && $stable(addr_q[0])
              && $stable(mr1_q[0]) && $stable(psrc_q[0]) && $stable(pdst_q[0])));

  // R2
  bg_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bg_q |=> ($stable(ctl_q[1]) && $stable(segctl_q[1]) && $stable(addr_q[1])
               && $stable(mr1_q[1]) && $stable(psrc_q[1]) && $stable(pdst_q[1])));

  // R5
  switch_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && (set_fg_i || set_bg_i)) |=>
      ($stable(ctl_q[0]) && $stable(ctl_q[1]) && $stable(mr1_q[0]) && $stable(mr1_q[1])
       && $stable(mr2_o)));

  // R10
  none_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_id == REG_NONE) |-> (rd_data_o == '0));
endmodule

// File: tb/fgbg_regbank_test.sv
module fgbg_regbank_test;
  localparam int CLK_PERIOD = 10;
  localparam int SEG_W   = 16;
  localparam int NUM_SEG = 4;
  localparam int ADDR_W  = 10;
  localparam int PTR_W   = 2;
  localparam int SIW     = 2;
  localparam int MASK_W  = SEG_W * NUM_SEG;
  localparam logic [SEG_W-1:0] CTL_RST = 16'h0c41;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic set_fg = 1'b0, set_bg = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_reg = '0, rd_reg = '0;
  logic [SIW-1:0] wr_seg = '0, rd_seg = '0;
  logic [SEG_W-1:0] wr_data = '0;
  logic [SEG_W-1:0] rd_data;
  logic bank_bg;
  logic [SEG_W-1:0] ctl, segctl;
  logic [ADDR_W-1:0] addr;
  logic [MASK_W-1:0] mr1, mr2;
  logic [PTR_W-1:0] psrc, pdst;

  always #(CLK_PERIOD/2) clk = ~clk;

  fgbg_regbank #(
    .SEG_W(SEG_W), .NUM_SEG(NUM_SEG), .ADDR_W(ADDR_W), .PTR_W(PTR_W), .CTL_RST(CTL_RST)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .set_fg_i(set_fg), .set_bg_i(set_bg),
    .wr_en_i(wr_en), .wr_reg_i(wr_reg), .wr_seg_i(wr_seg), .wr_data_i(wr_data),
    .rd_reg_i(rd_reg), .rd_seg_i(rd_seg), .rd_data_o(rd_data), .bank_bg_o(bank_bg),
    .ctl_o(ctl), .segctl_o(segctl), .addr_o(addr), .mr1_o(mr1),
    .psrc_o(psrc), .pdst_o(pdst), .mr2_o(mr2)
  );

  int checks = 0;
  int errors = 0;

  // reference model
  logic [SEG_W-1:0]  m_ctl [2];
  logic [SEG_W-1:0]  m_sctl [2];
  logic [ADDR_W-1:0] m_addr [2];
  logic [MASK_W-1:0] m_mr1 [2];
  logic [PTR_W-1:0]  m_ps [2];
  logic [PTR_W-1:0]  m_pd [2];
  logic [MASK_W-1:0] m_mr2;
  logic m_bg;

  task automatic model_reset();
    for (int b = 0; b < 2; b++) begin
      m_ctl[b] = CTL_RST; m_sctl[b] = '0; m_addr[b] = '0;
      m_mr1[b] = '0; m_ps[b] = '0; m_pd[b] = '0;
    end
    m_mr2 = '0;
    m_bg = 1'b0;
  endtask

  task automatic model_step(input bit we, input logic [2:0] r, input int seg,
                            input logic [SEG_W-1:0] d, input bit sf, input bit sb);
    int b;
    b = int'(m_bg);
    if (we) begin
      case (r)
        3'd0: m_ctl[b] = d;
        3'd1: m_sctl[b] = d;
        3'd2: m_addr[b] = d[ADDR_W-1:0];
        3'd3: m_mr1[b][seg*SEG_W +: SEG_W] = d;
        3'd4: m_ps[b] = d[PTR_W-1:0];
        3'd5: m_pd[b] = d[PTR_W-1:0];
        3'd6: m_mr2[seg*SEG_W +: SEG_W] = d;
        default: ;
      endcase
    end
    if (sb && !sf) m_bg = 1'b1;
    else if (sf && !sb) m_bg = 1'b0;
  endtask

  function automatic logic [SEG_W-1:0] exp_rd(input logic [2:0] r, input int seg);
    int b;
    b = int'(m_bg);
    case (r)
      3'd0: return m_ctl[b];
      3'd1: return m_sctl[b];
      3'd2: return SEG_W'(m_addr[b]);
      3'd3: return m_mr1[b][seg*SEG_W +: SEG_W];
      3'd4: return SEG_W'(m_ps[b]);
      3'd5: return SEG_W'(m_pd[b]);
      3'd6: return m_mr2[seg*SEG_W +: SEG_W];
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [MASK_W-1:0] act, input logic [MASK_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    int b;
    b = int'(m_bg);
    chk(tag, "bank", MASK_W'(bank_bg), MASK_W'(m_bg));
    chk(tag, "ctl", MASK_W'(ctl), MASK_W'(m_ctl[b]));
    chk(tag, "segctl", MASK_W'(segctl), MASK_W'(m_sctl[b]));
    chk(tag, "addr", MASK_W'(addr), MASK_W'(m_addr[b]));
    chk(tag, "mr1", mr1, m_mr1[b]);
    chk(tag, "psrc", MASK_W'(psrc), MASK_W'(m_ps[b]));
    chk(tag, "pdst", MASK_W'(pdst), MASK_W'(m_pd[b]));
    chk(tag, "mr2", mr2, m_mr2);
    chk(tag, "rd_data", MASK_W'(rd_data), MASK_W'(exp_rd(rd_reg, int'(rd_seg))));
  endtask

  // inputs set after a falling edge; results checked after the next falling edge
  task automatic step(input bit we, input logic [2:0] r, input int seg,
                      input logic [SEG_W-1:0] d, input bit sf, input bit sb,
                      input logic [2:0] rr, input int rs, input string tag);
    wr_en = we; wr_reg = r; wr_seg = SIW'(seg); wr_data = d;
    set_fg = sf; set_bg = sb;
    @(posedge clk);
    model_step(we, r, seg, d, sf, sb);
    @(negedge clk);
    wr_en = 1'b0; set_fg = 1'b0; set_bg = 1'b0;
    rd_reg = rr; rd_seg = SIW'(rs);
    #1;
    check_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [SEG_W-1:0] saved;
    void'($urandom(32'd7321));
    model_reset();
    repeat (3) @(negedge clk);
    rd_reg = 3'd0;
    #1;
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check_all("R1");
    step(1'b0, 3'd0, 0, '0, 1'b0, 1'b0, 3'd3, 2, "R1");

    // R2 / R3 / R4: write foreground, move to background, return
    step(1'b1, 3'd0, 0, 16'h1234, 1'b0, 1'b0, 3'd0, 0, "R2");
    step(1'b0, 3'd0, 0, '0, 1'b0, 1'b1, 3'd0, 0, "R3");
    chk("R3", "bg ctl untouched", MASK_W'(ctl), MASK_W'(CTL_RST));
    step(1'b1, 3'd0, 0, 16'h0000, 1'b0, 1'b0, 3'd0, 0, "R2");
    step(1'b1, 3'd1, 0, 16'hbeef, 1'b0, 1'b0, 3'd1, 0, "R2");
    step(1'b0, 3'd0, 0, '0, 1'b1, 1'b0, 3'd0, 0, "R4");
    chk("R4", "fg ctl restored", MASK_W'(ctl), MASK_W'(16'h1234));
    chk("R4", "fg segctl", MASK_W'(segctl), '0);

    // R5: toggle without writes
    saved = ctl;
    for (int i = 0; i < 6; i++) begin
      step(1'b0, 3'd0, 0, '0, (i % 2) == 1, (i % 2) == 0, 3'd1, 0, "R5");
    end
    chk("R5", "ctl after toggles", MASK_W'(ctl), MASK_W'(saved));

    // R6: write coincident with switch lands in old set
    step(1'b1, 3'd0, 0, 16'h5a5a, 1'b0, 1'b1, 3'd0, 0, "R6");
    chk("R6", "bg ctl not written", MASK_W'(ctl), MASK_W'(16'h0000));
    step(1'b0, 3'd0, 0, '0, 1'b1, 1'b0, 3'd0, 0, "R6");
    chk("R6", "fg ctl written", MASK_W'(ctl), MASK_W'(16'h5a5a));

    // R7: both pulses hold selection
    step(1'b0, 3'd0, 0, '0, 1'b1, 1'b1, 3'd0, 0, "R7");
    chk("R7", "still fg", MASK_W'(bank_bg), '0);
    step(1'b0, 3'd0, 0, '0, 1'b0, 1'b1, 3'd0, 0, "R7");
    step(1'b0, 3'd0, 0, '0, 1'b1, 1'b1, 3'd0, 0, "R7");
    chk("R7", "still bg", MASK_W'(bank_bg), MASK_W'(1'b1));

    // R8: single mask segment
    step(1'b1, 3'd3, 2, 16'hc3c3, 1'b0, 1'b0, 3'd3, 2, "R8");
    chk("R8", "mr1 segment 2", mr1, MASK_W'(64'h0000_c3c3_0000_0000));
    step(1'b1, 3'd3, 0, 16'h0101, 1'b0, 1'b0, 3'd3, 0, "R8");
    chk("R8", "mr1 segments 2,0", mr1, MASK_W'(64'h0000_c3c3_0000_0101));

    // R9: shared mask visible in both sets
    step(1'b1, 3'd6, 3, 16'hf00d, 1'b0, 1'b0, 3'd6, 3, "R9");
    step(1'b0, 3'd0, 0, '0, 1'b1, 1'b0, 3'd6, 3, "R9");
    chk("R9", "mr2 in fg", mr2, MASK_W'(64'hf00d_0000_0000_0000));

    // R10: code 7
    step(1'b1, 3'd7, 1, 16'hffff, 1'b0, 1'b0, 3'd7, 1, "R10");
    chk("R10", "code7 read", MASK_W'(rd_data), '0);

    // R11: truncation
    step(1'b1, 3'd2, 0, 16'hffff, 1'b0, 1'b0, 3'd2, 0, "R11");
    chk("R11", "addr trunc", MASK_W'(rd_data), MASK_W'(16'h03ff));
    step(1'b1, 3'd4, 0, 16'hfffe, 1'b0, 1'b0, 3'd4, 0, "R11");
    chk("R11", "psrc trunc", MASK_W'(psrc), MASK_W'(2'd2));
    step(1'b1, 3'd5, 0, 16'h8001, 1'b0, 1'b0, 3'd5, 0, "R11");

    // random mix, R2 and R10 against the model
    for (int i = 0; i < 3000; i++) begin
      bit we, sf, sb;
      logic [2:0] r, rr;
      int seg, rs;
      we  = ($urandom % 3) != 0;
      r   = 3'($urandom);
      seg = int'($urandom % NUM_SEG);
      sf  = ($urandom % 6) == 0;
      sb  = ($urandom % 6) == 0;
      rr  = 3'($urandom);
      rs  = int'($urandom % NUM_SEG);
      step(we, r, seg, 16'($urandom), sf, sb, rr, rs, (i % 2) ? "R2" : "R10");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule